// File: doc/BRIEF.md
# Indexed Byte Port with Region Locks

This block reaches a byte-wide memory through a narrow window of four host ports. The host first loads a 16-bit pointer one byte at a time, through one port for the low byte and one for the high byte. It then moves a byte through the data port. A data write stores the byte and returns the pointer to zero. A data read leaves the pointer where it is, so one location can be polled repeatedly without loading it again. The fourth port is a dead slot.

Two lock bits each guard a fixed 16-byte window of the memory. While a window is locked, reads in it give 0xFF and writes in it are dropped. A lock is never set or cleared directly: each request on the lock-toggle input inverts one chosen bit. Pointers at or above the memory depth behave like locked ones, and they never alias onto real locations. The memory is an internal synchronous array. Every read strobe is answered one cycle later by a single-cycle valid pulse carrying the byte.

Top module: `idx_byte_port`

## Requirements
- R1: A write to port 0 replaces bits 7:0 of the pointer, and a write to port 1 replaces bits 15:8. The other byte is kept in both cases.
- R2: A write to port 3 stores the data byte at the pointer address. It then sets the pointer to zero, and it does so even when the store itself is refused.
- R3: A read strobe on port 3 gives the byte at the pointer on `rd_data` in the next cycle, with `rd_valid` high for exactly that cycle. The pointer does not change. `rd_valid` is low in any cycle that follows a cycle without a read strobe.
- R4: Reads of ports 0, 1 and 2 give 0xFF in the next cycle. A write to port 2 changes neither the memory nor the pointer.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F read as 0xFF and writes to them are discarded.
- R6: While lock bit 1 is set, addresses 0x30 to 0x3F read as 0xFF and writes to them are discarded.
- R7: A pulse on `lock_tgl` inverts the lock bit chosen by `lock_sel` (0 or 1) and leaves the other bit alone. Two pulses on the same bit return it to its earlier value.
- R8: With the pointer at or above the memory depth (128 bytes by default), a port-3 read gives 0xFF and a port-3 write changes no memory location.
- R9: Reset clears the pointer and both lock bits. `rd_valid` is low during reset and `rd_data` reads 0xFF.
- R10: A lock toggle that falls in the same cycle as a port-3 access takes effect only from the next cycle. The access is judged against the lock state that held before the toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Host port: 0 pointer low, 1 pointer high, 2 unused, 3 data |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse, one cycle after a read strobe |
| lock_tgl | input | 1 | Lock toggle request |
| lock_sel | input | 1 | Index of the lock bit to invert |

## Verification
A lock toggle and a data-port access can land in the same cycle. That creates a race between the new lock state and the access it might guard. The bench provokes it with directed reads at an address inside a window, with the toggle applied alongside, both from the unlocked and from the locked state. The random phase also attaches toggles to accesses. A reference model then judges each access against the lock bits as they stood before that cycle, and applies the inversion only afterwards.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    typedef enum logic [1:0] {
        PORT_PTR_LO = 2'd0,
        PORT_PTR_HI = 2'd1,
        PORT_SPARE  = 2'd2,
        PORT_DATA   = 2'd3
    } port_e;

    // read response state of the top level
    typedef struct packed {
        logic rvalid;
        logic pass;
    } resp_t;

endpackage

// File: rtl/ibp_ptr.sv
module ibp_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       port,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] ptr
);
    import ibp_pkg::*;

    localparam int HI_W = PTR_W - 8;

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr) begin
            case (port_e'(port))
                PORT_PTR_LO: ptr_d[7:0]       = wdata;
                PORT_PTR_HI: ptr_d[PTR_W-1:8] = wdata[HI_W-1:0];
                PORT_DATA:   ptr_d            = '0;
                default:     ptr_d            = ptr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    p_lo_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && port == 2'd0) |=> (ptr_q[7:0] == $past(wdata)) &&
                                 (ptr_q[PTR_W-1:8] == $past(ptr_q[PTR_W-1:8])));

    p_data_wr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && port == 2'd3) |=> (ptr_q == '0));

    p_spare_wr_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && port == 2'd2) |=> $stable(ptr_q));

endmodule

// File: rtl/ibp_lock.sv
module ibp_lock #(
    parameter int PTR_W     = 16,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int WIN_BYTES = 16,
    localparam int IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl,
    input  logic [IDX_W-1:0] tgl_idx,
    input  logic [PTR_W-1:0] addr,
    output logic             hit
);

    logic [NUM_LOCKS-1:0] lock_d, lock_q;
    logic [NUM_LOCKS-1:0] in_win;

    always_comb begin
        lock_d = lock_q;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (tgl && tgl_idx == IDX_W'(i)) lock_d[i] = ~lock_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_win
        localparam logic [PTR_W-1:0] LO = PTR_W'(LOCK_BASE + g * WIN_BYTES);
        localparam logic [PTR_W-1:0] HI = PTR_W'(LOCK_BASE + (g + 1) * WIN_BYTES - 1);
        assign in_win[g] = (addr >= LO) && (addr <= HI);

        p_toggle_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (tgl && tgl_idx == IDX_W'(g)) |=> (lock_q[g] != $past(lock_q[g])));

        p_no_toggle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(tgl && tgl_idx == IDX_W'(g)) |=> $stable(lock_q[g]));
    end

    assign hit = |(in_win & lock_q);

endmodule

// File: rtl/ibp_mem.sv
module ibp_mem #(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/idx_byte_port.sv
module idx_byte_port #(
    parameter int DEPTH     = 128,
    parameter int PTR_W     = 16,
    parameter int NUM_LOCKS = 2,
    parameter int LOCK_BASE = 32,
    parameter int WIN_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       lock_tgl,
    input  logic       lock_sel
);
    import ibp_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic [PTR_W-1:0] ptr;
    logic             lock_hit;
    logic             in_range;
    logic             blocked;
    logic             mem_we, mem_re;
    logic [7:0]       mem_rdata;
    resp_t            resp_d, resp_q;

    ibp_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en),
        .port  (port_sel),
        .wdata (wr_data),
        .ptr   (ptr)
    );

    ibp_lock #(
        .PTR_W     (PTR_W),
        .NUM_LOCKS (NUM_LOCKS),
        .LOCK_BASE (LOCK_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl     (lock_tgl),
        .tgl_idx (lock_sel),
        .addr    (ptr),
        .hit     (lock_hit)
    );

    ibp_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr[AW-1:0]),
        .wdata (wr_data),
        .re    (mem_re),
        .raddr (ptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        in_range      = ptr < PTR_W'(DEPTH);
        blocked       = !in_range || lock_hit;
        mem_we        = wr_en && (port_e'(port_sel) == PORT_DATA) && !blocked;
        mem_re        = rd_en && (port_e'(port_sel) == PORT_DATA) && !blocked;
        resp_d.rvalid = rd_en;
        resp_d.pass   = mem_re;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rd_valid = resp_q.rvalid;
    assign rd_data  = resp_q.pass ? mem_rdata : 8'hFF;

    p_rvalid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rvalid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_rd_keeps_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> $stable(ptr));

    p_side_port_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel != 2'd3) |=> (rd_data == 8'hFF));

    p_range_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd3 && ptr >= PTR_W'(DEPTH)) |=> (rd_data == 8'hFF));

    p_locked_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel == 2'd3 && lock_hit) |=> (rd_data == 8'hFF));

endmodule

// File: tb/idx_byte_port_tb_top.sv
`timescale 1ns/1ps
module idx_byte_port_tb_top;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       lock_tgl = 1'b0;
    logic       lock_sel = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  m_mem [DEPTH];
    logic [15:0] m_ptr;
    logic [1:0]  m_lk;

    always #2.5 clk = ~clk;

    idx_byte_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_sel (port_sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .lock_tgl (lock_tgl),
        .lock_sel (lock_sel)
    );

    function automatic bit m_locked(input logic [15:0] a);
        return (m_lk[0] && a >= 16'h20 && a <= 16'h2F) ||
               (m_lk[1] && a >= 16'h30 && a <= 16'h3F);
    endfunction

    function automatic bit m_blocked(input logic [15:0] a);
        return (a >= 16'(DEPTH)) || m_locked(a);
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] p);
        if (p != 2'd3 || m_blocked(m_ptr)) return 8'hFF;
        return m_mem[m_ptr[6:0]];
    endfunction

    function automatic string m_tag(input logic [1:0] p, input bit t);
        if (p != 2'd3)              return "R4";
        if (m_ptr >= 16'(DEPTH))    return "R8";
        if (t)                      return "R10";
        if (m_lk[0] && m_ptr >= 16'h20 && m_ptr <= 16'h2F) return "R5";
        if (m_lk[1] && m_ptr >= 16'h30 && m_ptr <= 16'h3F) return "R6";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one host cycle; reads are checked on the response cycle
    task automatic op(input logic [1:0] p, input bit w, input bit r,
                      input logic [7:0] d, input bit t, input bit ti, input string tag);
        logic [7:0] exp;
        exp = m_read(p);
        @(negedge clk);
        port_sel = p; wr_en = w; rd_en = r; wr_data = d; lock_tgl = t; lock_sel = ti;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; lock_tgl = 0;
        if (r) chk(tag, {rd_valid, rd_data}, {1'b1, exp});
        else   chk("R3", {rd_valid, 8'h00}, {1'b0, 8'h00});
        if (w) begin
            case (p)
                2'd0: m_ptr[7:0]  = d;
                2'd1: m_ptr[15:8] = d;
                2'd3: begin
                    if (!m_blocked(m_ptr)) m_mem[m_ptr[6:0]] = d;
                    m_ptr = '0;
                end
                default: ;
            endcase
        end
        if (t) m_lk[ti] = ~m_lk[ti];
    endtask

    task automatic set_ptr(input logic [15:0] a);
        op(2'd0, 1, 0, a[7:0], 0, 0, "R1");
        op(2'd1, 1, 0, a[15:8], 0, 0, "R1");
    endtask

    task automatic rd_at(input logic [15:0] a, input string tag);
        set_ptr(a);
        op(2'd3, 0, 1, 8'h00, 0, 0, tag);
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
        set_ptr(a);
        op(2'd3, 1, 0, d, 0, 0, "R2");
    endtask

    task automatic tgl(input bit ti);
        op(2'd2, 0, 0, 8'h00, 1, ti, "R7");
    endtask

    initial begin
        void'($urandom(32'd5150));
        m_ptr = '0;
        m_lk  = '0;
        repeat (3) @(negedge clk);
        chk("R9", {rd_valid, rd_data}, {1'b0, 8'hFF});
        rst_n = 1'b1;

        // fill memory
        for (int a = 0; a < DEPTH; a++) wr_at(16'(a), 8'(a * 3 + 1));

        // R1 pointer halves, R8 out of range
        set_ptr(16'h0045);
        op(2'd1, 1, 0, 8'h01, 0, 0, "R1");
        op(2'd3, 0, 1, 8'h00, 0, 0, "R8");
        op(2'd1, 1, 0, 8'h00, 0, 0, "R1");
        op(2'd3, 0, 1, 8'h00, 0, 0, "R1");

        // R2 write clears pointer; R3 repeat read keeps pointer
        wr_at(16'h0010, 8'hA5);
        op(2'd3, 0, 1, 8'h00, 0, 0, "R2");
        rd_at(16'h0010, "R2");
        op(2'd3, 0, 1, 8'h00, 0, 0, "R3");

        // R4 side ports and spare write
        set_ptr(16'h0011);
        op(2'd0, 0, 1, 8'h00, 0, 0, "R4");
        op(2'd1, 0, 1, 8'h00, 0, 0, "R4");
        op(2'd2, 0, 1, 8'h00, 0, 0, "R4");
        op(2'd2, 1, 0, 8'h77, 0, 0, "R4");
        op(2'd3, 0, 1, 8'h00, 0, 0, "R4");

        // R5 window 0
        tgl(0);
        rd_at(16'h0020, "R5");
        rd_at(16'h002F, "R5");
        rd_at(16'h001F, "R5");
        rd_at(16'h0030, "R5");
        wr_at(16'h0025, 8'h5A);
        tgl(0);
        rd_at(16'h0025, "R5");

        // R6 window 1
        tgl(1);
        rd_at(16'h0030, "R6");
        rd_at(16'h003F, "R6");
        rd_at(16'h0040, "R6");
        rd_at(16'h002A, "R6");
        wr_at(16'h0033, 8'hC3);
        tgl(1);
        rd_at(16'h0033, "R6");

        // R7 double toggle restores
        tgl(0); tgl(0);
        rd_at(16'h0021, "R7");

        // R8 out-of-range write must not alias
        wr_at(16'h0080, 8'hEE);
        wr_at(16'h0100, 8'hDD);
        rd_at(16'h0000, "R8");
        rd_at(16'h00FF, "R8");

        // R10 toggle in the same cycle as access
        set_ptr(16'h0022);
        op(2'd3, 0, 1, 8'h00, 1, 0, "R10");
        op(2'd3, 0, 1, 8'h00, 1, 0, "R10");
        op(2'd3, 0, 1, 8'h00, 0, 0, "R10");
        set_ptr(16'h0036);
        op(2'd3, 1, 0, 8'h99, 1, 1, "R10");
        rd_at(16'h0036, "R10");
        tgl(1);
        wr_at(16'h0036, 8'h98);
        rd_at(16'h0036, "R10");

        // R9 reset clears pointer and locks
        tgl(0);
        set_ptr(16'h0107);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", {rd_valid, rd_data}, {1'b0, 8'hFF});
        rst_n = 1'b1;
        m_ptr = '0;
        m_lk  = '0;
        op(2'd3, 0, 1, 8'h00, 0, 0, "R9");
        rd_at(16'h0024, "R9");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int k;
            logic [1:0] p;
            bit w, r, t, ti;
            logic [7:0] d;
            k  = $urandom_range(0, 99);
            t  = ($urandom_range(0, 9) == 0);
            ti = 1'($urandom_range(0, 1));
            d  = 8'($urandom);
            w = 0; r = 0;
            if (k < 20) begin
                p = 2'd0; w = 1;
                d = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(32, 63)) : 8'($urandom_range(0, 140));
            end else if (k < 28) begin
                p = 2'd1; w = 1;
                d = ($urandom_range(0, 4) == 0) ? 8'($urandom) : 8'h00;
            end else if (k < 50) begin
                p = 2'd3; w = 1;
            end else if (k < 85) begin
                p = 2'd3; r = 1;
            end else if (k < 92) begin
                p = 2'($urandom_range(0, 2)); r = 1;
            end else begin
                p = 2'd2; w = ($urandom_range(0, 1) == 1);
            end
            op(p, w, r, d, t, ti, m_tag(p, t));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule